// File: doc/BRIEF.md
# Serial Flash Erase Command Decoder

This block is the target-side command front end of a serial flash for the three erase operations. It watches a four-wire serial bus in clock mode 0 or mode 3 and runs from a faster system clock. It brings the bus pins into that clock domain and shifts in an opcode and, where the command takes one, a 24-bit address, most significant bit first. It acts only when chip select returns high.

When a frame of the exact length for its opcode ends, the block checks the write-enable latch and the protected region. It then raises either a one-cycle erase request or a one-cycle reject flag. Both carry the erase kind and the aligned base address. An accepted erase also pulses a clear to the write-enable latch. The array, the erase timing and the status register live elsewhere.

Protection is given as a level on `prot_lvl`. Level 0 protects nothing. Level L > 0 protects the top 2^(ADDR_W-4+L) bytes. With the default 18-bit array that is the top eighth, quarter or half.

Top module: `spi_erase_decoder`

## Requirements
- R1: Opcode 0x20 in a 32-bit frame gives `erase_kind` 2'b01 (sector) and `erase_addr` equal to the low ADDR_W address bits with bits [11:0] cleared. Address bits at and above ADDR_W are ignored.
- R2: Opcode 0x52 in a 32-bit frame gives `erase_kind` 2'b10 (block) and `erase_addr` with bits [14:0] cleared.
- R3: Opcode 0x60 in an 8-bit frame gives `erase_kind` 2'b11 (whole array) and `erase_addr` of 0.
- R4: If `wel` is low when the frame ends, `erase_reject` pulses instead of `erase_req`. Kind and address are reported as for an accepted erase.
- R5: A sector or block erase whose aligned range reaches into the protected top region is rejected. The region is set by `prot_lvl` as described above.
- R6: A whole-array erase is rejected whenever `prot_lvl` is non-zero.
- R7: A frame that does not hold exactly 8 bits (opcode 0x60) or exactly 32 bits (opcodes 0x20 and 0x52) when chip select rises causes no request and no reject.
- R8: No result appears while `cs_n` is low. A result appears within 6 system clock cycles after `cs_n` rises.
- R9: `wel_clr` pulses in exactly the cycles in which `erase_req` pulses.
- R10: `so_oe` stays low at all times, so the serial output stays high-impedance.
- R11: Any other opcode causes neither a request nor a reject.
- R12: `erase_req` and `erase_reject` are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bus clock, mode 0 or mode 3 |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, MSB first |
| wel | input | 1 | Write-enable latch state |
| prot_lvl | input | BP_W | Protection level, 0 means none |
| so_oe | output | 1 | Serial output drive enable, always low |
| erase_req | output | 1 | One-cycle accepted erase request |
| erase_kind | output | 2 | 01 sector, 10 block, 11 whole array |
| erase_addr | output | ADDR_W | Aligned erase base address |
| erase_reject | output | 1 | One-cycle rejected erase flag |
| wel_clr | output | 1 | One-cycle write-enable latch clear |

## Verification
A miscounted bit counter or a slipped shift register shows up at the ports in two ways. A proper command can vanish, or a malformed frame can produce a result. Either is visible in the few cycles after chip select rises. A wrong alignment mask or a wrong protection limit gives the wrong address, or the wrong choice between accept and reject, on the very pulse that ends the frame. The scoreboard pairs every pulse with the frame that caused it. Frames of the wrong length, frames with unknown opcodes and protection corner cases sit next to good frames, so a stale or misplaced result cannot hide.

// File: rtl/spi_erase_decoder.sv
module spi_erase_decoder #(
  parameter int ADDR_W = 18,
  parameter int BP_W   = 2,
  parameter int SYNC_N = 2,
  parameter int SEC_SH = 12,
  parameter int BLK_SH = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              si,
  input  logic              wel,
  input  logic [BP_W-1:0]   prot_lvl,
  output logic              so_oe,
  output logic              erase_req,
  output logic [1:0]        erase_kind,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              erase_reject,
  output logic              wel_clr
);
  localparam int PROT_SH = ADDR_W - (1 << BP_W);
  localparam logic [ADDR_W:0] MEM_SZ = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [5:0] CNT_MAX = 6'd33;
  localparam logic [ADDR_W-1:0] SEC_MASK = ADDR_W'((1 << SEC_SH) - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((1 << BLK_SH) - 1);

  logic [SYNC_N-1:0] sclk_sy, cs_sy, si_sy;
  logic sclk_q, cs_q;
  logic [5:0] cnt;
  logic [7:0] op;
  logic [ADDR_W-1:0] adr;

  wire sclk_s = sclk_sy[SYNC_N-1];
  wire cs_s   = cs_sy[SYNC_N-1];
  wire si_s   = si_sy[SYNC_N-1];
  wire shift  = sclk_s & ~sclk_q & ~cs_s;
  wire cs_rise = cs_s & ~cs_q;
  wire cs_fall = ~cs_s & cs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      si_sy   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_N-2:0], sclk};
      cs_sy   <= {cs_sy[SYNC_N-2:0], cs_n};
      si_sy   <= {si_sy[SYNC_N-2:0], si};
      sclk_q  <= sclk_s;
      cs_q    <= cs_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      op  <= '0;
      adr <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (shift) begin
      cnt <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 6'd1;
      adr <= {adr[ADDR_W-2:0], si_s};
      if (cnt < 6'd8) op <= {op[6:0], si_s};
    end

  logic        dec_ok;
  logic [1:0]  dec_kind;
  logic [ADDR_W-1:0] dec_mask, dec_base;
  logic [ADDR_W:0] prot_span, prot_lim;
  logic        dec_prot, dec_allow;

  always_comb begin
    dec_ok   = 1'b0;
    dec_kind = 2'b00;
    dec_mask = '0;
    if (cnt == 6'd32 && op == 8'h20) begin
      dec_ok = 1'b1; dec_kind = 2'b01; dec_mask = SEC_MASK;
    end else if (cnt == 6'd32 && op == 8'h52) begin
      dec_ok = 1'b1; dec_kind = 2'b10; dec_mask = BLK_MASK;
    end else if (cnt == 6'd8 && op == 8'h60) begin
      dec_ok = 1'b1; dec_kind = 2'b11;
    end
  end

  assign dec_base  = (dec_kind == 2'b11) ? '0 : (adr & ~dec_mask);
  assign prot_span = (prot_lvl == '0) ? '0
                   : ((ADDR_W+1)'(1) << (PROT_SH + int'(prot_lvl)));
  assign prot_lim  = MEM_SZ - prot_span;
  assign dec_prot  = (dec_kind == 2'b11) ? (prot_lvl != '0)
                   : ({1'b0, dec_base | dec_mask} >= prot_lim);
  assign dec_allow = wel & ~dec_prot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      erase_req    <= 1'b0;
      erase_reject <= 1'b0;
      wel_clr      <= 1'b0;
      erase_kind   <= 2'b00;
      erase_addr   <= '0;
    end else begin
      erase_req    <= cs_rise & dec_ok & dec_allow;
      wel_clr      <= cs_rise & dec_ok & dec_allow;
      erase_reject <= cs_rise & dec_ok & ~dec_allow;
      if (cs_rise && dec_ok) begin
        erase_kind <= dec_kind;
        erase_addr <= dec_base;
      end
    end

  assign so_oe = 1'b0;
endmodule

// File: rtl/spi_erase_decoder_chk.sv
module spi_erase_decoder_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wel,
  input logic              erase_req,
  input logic              erase_reject,
  input logic [1:0]        erase_kind,
  input logic [ADDR_W-1:0] erase_addr,
  input logic              wel_clr
);
  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_req && erase_reject));
  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  assert_rej_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_reject |=> !erase_reject);
  assert_wel_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr == erase_req);
  assert_sec_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_kind == 2'b01) |-> erase_addr[11:0] == '0);
  assert_blk_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_kind == 2'b10) |-> erase_addr[14:0] == '0);
  assert_chip_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_kind == 2'b11) |-> erase_addr == '0);
  assert_wel_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wel));
  assert_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req || erase_reject) |-> cs_n);
endmodule

bind spi_erase_decoder spi_erase_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wel(wel),
  .erase_req(erase_req), .erase_reject(erase_reject),
  .erase_kind(erase_kind), .erase_addr(erase_addr), .wel_clr(wel_clr));

// File: tb/sim_spi_erase_decoder.sv
`timescale 1ns/1ps
module sim_spi_erase_decoder;
  localparam int AW = 18;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0, wel = 1'b1;
  logic [1:0] prot_lvl = 2'd0;
  logic so_oe, erase_req, erase_reject, wel_clr;
  logic [1:0] erase_kind;
  logic [AW-1:0] erase_addr;

  int checks = 0, failures = 0, events = 0, since_cs = 0;
  bit done = 0, prev_evt = 0;
  logic [AW+2:0] expq[$];

  always #4 clk = ~clk;

  spi_erase_decoder #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si), .wel(wel),
    .prot_lvl(prot_lvl), .so_oe(so_oe), .erase_req(erase_req),
    .erase_kind(erase_kind), .erase_addr(erase_addr),
    .erase_reject(erase_reject), .wel_clr(wel_clr));

  task automatic report(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every result pulse
  always @(negedge clk) if (rst_n && !done) begin
    since_cs = cs_n ? since_cs + 1 : 0;
    if (!cs_n && so_oe) report(0, "R10 so_oe", so_oe, 0);
    if (erase_req || erase_reject) begin
      events++;
      report(cs_n == 1'b1, "R8 result while cs_n low", cs_n, 1);
      report(since_cs <= 6, "R8 latency", since_cs, 6);
      report(!prev_evt, "R12 pulse width", prev_evt, 0);
      report(!(erase_req && erase_reject), "R12 exclusive", {erase_req, erase_reject}, 0);
      report(wel_clr == erase_req, "R9 wel_clr", wel_clr, erase_req);
      if (expq.size() == 0) report(0, "R7/R11 unexpected result", {erase_reject, erase_kind, erase_addr}, 0);
      else begin
        logic [AW+2:0] e;
        e = expq.pop_front();
        report({erase_reject, erase_kind, erase_addr} == e, "R1-6 result",
               {erase_reject, erase_kind, erase_addr}, e);
      end
    end else if (wel_clr) report(0, "R9 wel_clr without request", 1, 0);
    prev_evt = erase_req || erase_reject;
  end

  // Driver: sends nbits MSB first, pushes expectation, then checks completion
  task automatic frame(input logic [39:0] d, input int nbits, input bit mode3,
                       input bit exp_evt, input bit exp_rej, input logic [1:0] exp_kind,
                       input logic [AW-1:0] exp_addr, input string tag);
    int ev0;
    sclk = mode3;
    repeat (4) @(posedge clk);
    ev0 = events;
    if (exp_evt) expq.push_back({exp_rej, exp_kind, exp_addr});
    cs_n = 1'b0;
    repeat (4) @(posedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sclk = 1'b0; si = d[i];
      repeat (4) @(posedge clk);
      sclk = 1'b1;
      repeat (4) @(posedge clk);
    end
    sclk = mode3;
    repeat (4) @(posedge clk);
    report(events == ev0, {tag, " R8 nothing before cs_n rises"}, events - ev0, 0);
    cs_n = 1'b1;
    repeat (12) @(posedge clk);
    report(events - ev0 == (exp_evt ? 1 : 0), {tag, " result count"}, events - ev0, exp_evt);
    report(expq.size() == 0, {tag, " scoreboard drained"}, expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    report(!erase_req && !erase_reject && !wel_clr && !so_oe, "reset R12", {erase_req, erase_reject, wel_clr}, 0);

    frame({8'h20, 24'h012345}, 32, 0, 1, 0, 2'b01, 18'h12000, "R1 sector mode0");
    frame({8'h20, 24'hFC1000}, 32, 1, 1, 0, 2'b01, 18'h01000, "R1 sector high bits mode3");
    frame({8'h52, 24'h01ABCD}, 32, 1, 1, 0, 2'b10, 18'h18000, "R2 block");
    frame({8'h60}, 8, 0, 1, 0, 2'b11, 18'h0, "R3 chip");
    wel = 1'b0;
    frame({8'h20, 24'h012345}, 32, 0, 1, 1, 2'b01, 18'h12000, "R4 sector no wel");
    frame({8'h60}, 8, 1, 1, 1, 2'b11, 18'h0, "R4 chip no wel");
    wel = 1'b1;
    prot_lvl = 2'd1;
    frame({8'h20, 24'h037FFF}, 32, 0, 1, 0, 2'b01, 18'h37000, "R5 sector below limit");
    frame({8'h20, 24'h038000}, 32, 0, 1, 1, 2'b01, 18'h38000, "R5 sector at limit");
    frame({8'h52, 24'h030123}, 32, 0, 1, 0, 2'b10, 18'h30000, "R5 block below limit");
    frame({8'h60}, 8, 0, 1, 1, 2'b11, 18'h0, "R6 chip protected");
    prot_lvl = 2'd2;
    frame({8'h52, 24'h030123}, 32, 0, 1, 1, 2'b10, 18'h30000, "R5 block protected lvl2");
    frame({8'h20, 24'h02FFFF}, 32, 1, 1, 0, 2'b01, 18'h2F000, "R5 sector below lvl2");
    prot_lvl = 2'd3;
    frame({8'h52, 24'h018000}, 32, 0, 1, 0, 2'b10, 18'h18000, "R5 block below lvl3");
    frame({8'h52, 24'h020000}, 32, 0, 1, 1, 2'b10, 18'h20000, "R5 block at lvl3");
    prot_lvl = 2'd0;
    frame({8'h60, 24'h000000}, 32, 0, 0, 0, 2'b00, 18'h0, "R7 chip with 32 bits");
    frame({8'h20}, 8, 0, 0, 0, 2'b00, 18'h0, "R7 sector with 8 bits");
    frame({8'h20, 24'h012345} >> 1, 31, 0, 0, 0, 2'b00, 18'h0, "R7 31 bits");
    frame({8'h20, 24'h012345, 1'b1}, 33, 1, 0, 0, 2'b00, 18'h0, "R7 33 bits");
    frame({8'h60, 1'b0}, 9, 0, 0, 0, 2'b00, 18'h0, "R7 chip 9 bits");
    frame({8'hD8, 24'h012345}, 32, 0, 0, 0, 2'b00, 18'h0, "R11 unknown opcode");
    frame({8'h06}, 8, 0, 0, 0, 2'b00, 18'h0, "R11 unknown short opcode");
    frame({8'h52, 24'hFFFFFF}, 32, 1, 1, 0, 2'b10, 18'h38000, "R2 block top");
    report(so_oe == 1'b0, "R10 so_oe idle", so_oe, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule